// File: doc/BRIEF.md
# Fractional-Rate Asynchronous Serial Transmitter

This block sends words on a single serial line using start, data and stop framing. The time given to each bit is a fixed-point count of system clocks. It has a 16-bit integer part and a 6-bit fraction in units of 1/64 clock. The fractional part is added into a running remainder at every bit. Whenever that sum passes one whole clock, the bit is stretched by one clock. Single bit edges therefore move by one clock, but over many bits the average rate equals the programmed period exactly. The word length can be set anywhere from 1 to 32 bits.

Software writes a configuration word while the block is disabled and then raises the enable. After that it pushes words through a one-word holding buffer. The buffer-empty flag says when the next word can be written. If a word is written while a frame is on the line, it goes out right behind the current stop bit. This keeps the stream continuous with no idle gap between frames.

Top module: `frac_uart_tx`

## Requirements
- R1: After reset, and on every clock edge where `en` is low, `txd` is high (idle), `buf_empty` is 1 and the fractional remainder is cleared to zero.
- R2: A frame is one low start bit, then `cfg[4:0]+1` data bits sent least-significant bit first, then one high stop bit. After the frame the line returns to high.
- R3: Each bit lasts P clocks plus possibly one extra clock. P is `cfg[31:16]`. The fraction F is `cfg[15:10]`. At the start of each bit, F is added to a 6-bit remainder. If that addition reaches 64 or more, 64 is subtracted and the bit gets one extra clock. The remainder carries over between bits and between frames for as long as `en` stays high.
- R4: An integer period P of 0 or 1 is treated as 2, so every bit lasts at least 2 clocks.
- R5: A `wr_valid` pulse while `buf_empty` is 1 and `en` is high stores `wr_data`, and `buf_empty` reads 0 on the next cycle. If the line is idle, the start bit begins one cycle after that.
- R6: A word held in the buffer when a stop bit ends starts its start bit on the very next clock. `buf_empty` returns to 1 when the word moves out of the buffer, which is when its start bit begins.
- R7: A `wr_valid` pulse while `buf_empty` is 0, or while `en` is low, is ignored. The held word and the line output are unchanged.
- R8: Dropping `en` during a frame aborts it. The line goes high on the next edge and the held word is discarded.
- R9: With `cfg[4:0]` = 31, a full 32-bit word is sent with one stop bit.
- R10: Configuration bits 9:5 have no effect on timing or framing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle for configuration |
| cfg | input | 32 | [31:16] integer period, [15:10] fraction (1/64 clock), [4:0] data length minus one |
| wr_data | input | 32 | Word to send, LSB first |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| buf_empty | output | 1 | Holding buffer can accept a word |
| txd | output | 1 | Serial line, idle high |

## Verification
The bench targets four things. First, the exact clock on which each bit edge lands when the fraction makes the carry fire on some bits and not others. A design that dropped the carry, or reset the remainder at each frame, would drift by a clock within a few bits. Second, periods of 0 and 1. Without the clamp these would give one-clock or endless bits. Third, refilling the buffer during a frame. This exposes a one-cycle idle gap or a lost word at the frame boundary. Fourth, a second write into a full buffer, an abort through `en`, and the 32-bit word length. Errors here would show as an overwritten word, a line left low, or a frame cut short by a wrapped bit index.

// File: rtl/frac_tx_pkg.sv
// Package: shared state encoding for the fractional-rate transmitter.
// Assumes nothing beyond being compiled before the modules that import it.
package frac_tx_pkg;

    // Position in the frame currently on the line.
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_phase_t;

endpackage

// File: rtl/frac_tx_timer.sv
// Bit-duration generator. It holds the running fractional remainder and gives
// the length, minus one, of the bit that begins when 'step' is high.
// Assumes: 'step' pulses once at the first clock of every bit; the period
// inputs are stable while 'en' is high.
module frac_tx_timer #(
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 6,
    parameter int MIN_PER = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic [INT_W-1:0] int_per,
    input  logic [FRAC_W-1:0] frac_per,
    output logic [INT_W:0]   dur_m1
);
    localparam int DW = INT_W + 1;

    logic [FRAC_W-1:0] rem_q;
    logic [FRAC_W:0]   rem_sum;
    logic              carry;
    logic [DW-1:0]     per_clamped;

    // Add the fraction into the remainder; the top bit is the extra clock.
    always_comb begin
        rem_sum = {1'b0, rem_q} + {1'b0, frac_per};
        carry   = rem_sum[FRAC_W];
    end

    // Raise a too-short integer period to the minimum and add the carry.
    always_comb begin
        if ({1'b0, int_per} < DW'(MIN_PER))
            per_clamped = DW'(MIN_PER);
        else
            per_clamped = {1'b0, int_per};
        dur_m1 = per_clamped + DW'(carry) - DW'(1);
    end

    // Keep the remainder; clear it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= '0;
        else if (!en)
            rem_q <= '0;
        else if (step)
            rem_q <= rem_sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/frac_tx_holdbuf.sv
// One-word holding buffer between the write port and the frame engine.
// Assumes: 'take' is only raised while 'full' is set, so a write and a take
// never happen on the same edge.
module frac_tx_holdbuf #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Occupancy: set by an accepted write, cleared by the engine or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (!en)
            full <= 1'b0;
        else if (take)
            full <= 1'b0;
        else if (wr_valid)
            full <= 1'b1;
    end

    // Payload: captured only when the buffer is free and running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (en && wr_valid && !full)
            data <= wr_data;
    end

endmodule

// File: rtl/frac_tx_framer.sv
// Frame engine: walks start, data and stop bits, counts each bit's clocks
// and drives the registered line output.
// Assumes: 'dur_m1' is at least 1 and is valid in the cycle 'step' is raised;
// 'len_m1' is sampled at frame start.
module frac_tx_framer
    import frac_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 5,
    parameter int CNT_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [CNT_W-1:0]  dur_m1,
    output logic              take,
    output logic              step,
    output logic              txd
);

    tx_phase_t         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic [LEN_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic              bit_end;
    logic              begin_frame;

    // Decide when a bit finishes and whether a new frame starts now.
    always_comb begin
        bit_end     = (phase_q != TX_IDLE) && (cnt_q == '0);
        begin_frame = hold_full &&
                      ((phase_q == TX_IDLE) || (phase_q == TX_STOP && bit_end));
        take        = en && begin_frame;
        step        = en && (begin_frame ||
                      (bit_end && phase_q != TX_STOP));
    end

    // Sequence the frame and hold the line level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= TX_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            idx_q   <= '0;
            len_q   <= '0;
            txd     <= 1'b1;
        end else if (begin_frame) begin
            phase_q <= TX_START;
            cnt_q   <= dur_m1;
            shift_q <= hold_data;
            idx_q   <= '0;
            len_q   <= len_m1;
            txd     <= 1'b0;
        end else if (bit_end) begin
            unique case (phase_q)
                TX_START: begin
                    phase_q <= TX_DATA;
                    cnt_q   <= dur_m1;
                    txd     <= shift_q[0];
                end
                TX_DATA: begin
                    cnt_q <= dur_m1;
                    if (idx_q == len_q) begin
                        phase_q <= TX_STOP;
                        txd     <= 1'b1;
                    end else begin
                        shift_q <= shift_q >> 1;
                        txd     <= shift_q[1];
                        idx_q   <= idx_q + LEN_W'(1);
                    end
                end
                TX_STOP: begin
                    phase_q <= TX_IDLE;
                    txd     <= 1'b1;
                end
                default: phase_q <= TX_IDLE;
            endcase
        end else if (phase_q != TX_IDLE) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/frac_uart_tx.sv
// Top level of the fractional-rate serial transmitter. It unpacks the
// configuration word and joins the holding buffer, bit timer and frame engine.
// Assumes: 'cfg' changes only while 'en' is low.
module frac_uart_tx #(
    parameter int DATA_W = 32,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [31:0]       cfg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    output logic              buf_empty,
    output logic              txd
);
    localparam int LEN_W    = $clog2(DATA_W);
    localparam int INT_LSB  = 32 - INT_W;
    localparam int FRAC_LSB = INT_LSB - FRAC_W;
    localparam int CNT_W    = INT_W + 1;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              step;
    logic [CNT_W-1:0]  dur_m1;
    logic [INT_W-1:0]  int_per;
    logic [FRAC_W-1:0] frac_per;
    logic [LEN_W-1:0]  len_m1;

    // Split the configuration word into its fields.
    always_comb begin
        int_per   = cfg[31 -: INT_W];
        frac_per  = cfg[FRAC_LSB +: FRAC_W];
        len_m1    = cfg[LEN_W-1:0];
        buf_empty = !hold_full;
    end

    frac_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    frac_tx_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_PER(2)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .step     (step),
        .int_per  (int_per),
        .frac_per (frac_per),
        .dur_m1   (dur_m1)
    );

    frac_tx_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .len_m1    (len_m1),
        .dur_m1    (dur_m1),
        .take      (take),
        .step      (step),
        .txd       (txd)
    );

endmodule

// File: rtl/frac_uart_tx_chk.sv
// Checker for the transmitter's port behaviour, bound to every instance.
// Assumes: synchronous active-low reset on 'rst_n'.
module frac_uart_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic wr_valid,
    input logic buf_empty,
    input logic txd
);

    // R1: disabled means an idle-high line.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> txd);

    // R8: disabling discards any held word.
    p_drop_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> buf_empty);

    // R5: a write into a free buffer is held on the next cycle.
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_valid && buf_empty) |=> !buf_empty);

    // R4: a low level lasts at least two clocks while running.
    p_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $fell(txd)) |=> !txd);

    // R4: a high level lasts at least two clocks while running.
    p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(txd)) |=> txd);

endmodule

bind frac_uart_tx frac_uart_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .wr_valid  (wr_valid),
    .buf_empty (buf_empty),
    .txd       (txd)
);

// File: tb/sim_frac_uart_tx.sv
module sim_frac_uart_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [31:0] cfg = 32'h0004_0007;
    logic [31:0] wr_data = '0;
    logic        wr_valid = 1'b0;
    logic        buf_empty;
    logic        txd;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state
    bit          q[$];
    bit          m_hold = 1'b0;
    logic [31:0] m_data = '0;
    int          m_rem = 0;
    bit          m_tx = 1'b1;
    bit          m_acc;

    always #10 clk = ~clk;

    frac_uart_tx u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg(cfg),
        .wr_data(wr_data), .wr_valid(wr_valid),
        .buf_empty(buf_empty), .txd(txd)
    );

    function automatic void push_bit(bit v);
        int p = int'(cfg[31:16]);
        int d;
        if (p < 2) p = 2;
        d = p;
        m_rem += int'(cfg[15:10]);
        if (m_rem >= 64) begin
            m_rem -= 64;
            d++;
        end
        repeat (d) q.push_back(v);
    endfunction

    function automatic void push_frame(logic [31:0] w);
        int n = int'(cfg[4:0]) + 1;
        push_bit(1'b0);
        for (int i = 0; i < n; i++) push_bit(w[i]);
        push_bit(1'b1);
    endfunction

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n || !en) begin
            q.delete();
            m_hold = 1'b0;
            m_rem  = 0;
            m_tx   = 1'b1;
        end else begin
            m_acc = wr_valid && !m_hold;
            if (q.size() == 0 && m_hold) begin
                push_frame(m_data);
                m_hold = 1'b0;
            end
            if (q.size() != 0) m_tx = q.pop_front();
            else m_tx = 1'b1;
            if (m_acc) begin
                m_hold = 1'b1;
                m_data = wr_data;
            end
        end
    end

    task automatic check(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Compare with the model on every falling edge
    always @(negedge clk) begin
        if (chk_on) begin
            check(txd === m_tx, "txd", {31'd0, txd}, {31'd0, m_tx});
            check(buf_empty === !m_hold, "buf_empty", {31'd0, buf_empty}, {31'd0, !m_hold});
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL %s watchdog actual %0d expected below %0d", tag, cyc, 150000);
            finish_run();
        end
    end

    task automatic set_cfg(logic [31:0] c);
        en = 1'b0;
        cfg = c;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(logic [31:0] w);
        while (!buf_empty) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || m_hold || !buf_empty) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        tag = "R1";
        check(txd === 1'b1, "reset txd", {31'd0, txd}, 32'd1);
        check(buf_empty === 1'b1, "reset buf_empty", {31'd0, buf_empty}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;

        // R2: plain framing, period 4, 8 bits
        tag = "R2";
        set_cfg({16'd4, 6'd0, 5'd0, 5'd7});
        send(32'hA5);
        wait_idle();

        // R3 and R10: fraction 21/64 with junk in bits 9:5, carry across frames
        tag = "R3_R10";
        set_cfg({16'd3, 6'd21, 5'b10110, 5'd7});
        send(32'h3C);
        wait_idle();
        send(32'hC3);
        wait_idle();

        // R4: integer 0 with half fraction, then integer 1
        tag = "R4";
        set_cfg({16'd0, 6'd32, 5'd0, 5'd4});
        send(32'h15);
        wait_idle();
        set_cfg({16'd1, 6'd0, 5'd0, 5'd2});
        send(32'h5);
        wait_idle();

        // R5 and R6: refill during a frame, back to back
        tag = "R5_R6";
        set_cfg({16'd3, 6'd50, 5'd0, 5'd5});
        send(32'h2A);
        send(32'h15);
        send(32'h3F);
        send(32'h01);
        wait_idle();

        // R7: second write into a full buffer is dropped
        tag = "R7";
        send(32'h0F);
        wr_valid = 1'b1;
        wr_data  = 32'h30;
        @(negedge clk);
        wr_valid = 1'b0;
        send(32'h11);
        wr_valid = 1'b1;
        wr_data  = 32'h22;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();

        // R9: full 32-bit word
        tag = "R9";
        set_cfg({16'd2, 6'd40, 5'd0, 5'd31});
        send(32'hDEADBEEF);
        send(32'h80000001);
        wait_idle();

        // R8: abort a frame, write while disabled is ignored
        tag = "R8";
        set_cfg({16'd5, 6'd0, 5'd0, 5'd7});
        send(32'h00);
        send(32'h55);
        repeat (12) @(negedge clk);
        en = 1'b0;
        wr_valid = 1'b1;
        wr_data = 32'h77;
        @(negedge clk);
        wr_valid = 1'b0;
        check(txd === 1'b1, "abort txd", {31'd0, txd}, 32'd1);
        check(buf_empty === 1'b1, "abort buf_empty", {31'd0, buf_empty}, 32'd1);
        @(negedge clk);
        en = 1'b1;
        repeat (20) @(negedge clk);
        check(txd === 1'b1, "idle after abort", {31'd0, txd}, 32'd1);
        send(32'h81);
        wait_idle();

        chk_on = 1'b0;
        done = 1'b1;
        finish_run();
    end

endmodule